// File: doc/BRIEF.md
# Pixel Capture and Control Formatter

This block takes a parallel video bus and its three timing lines (line sync, frame sync and data enable) on the pixel clock. It samples them on a rising or a falling clock edge, chosen by configuration. Each sampled pixel becomes a 24-bit word, masked to the configured colour depth. The block decides, pixel by pixel, whether the three control bits travel with the word. The result leaves through a registered output with a valid strobe and a flag that marks when control bits are present.

Output stays quiet until the data-enable line has changed level once after reset. That change is the point where the downstream link locks to pixel data. A small alignment state machine tracks it with three states. `ST_ARM` waits for the first captured sample and takes its data-enable level as the reference (transition ARM to WAIT). `ST_WAIT` compares each new sample with that level and leaves on the first difference (transition WAIT to RUN). `ST_RUN` forwards every captured sample and does not leave again until reset. Everything on the link side (serializing, coding, framing, crossing into the link clock) sits in later blocks.

Top module: `pix_capture_fmt`

## Requirements
- R1: The width code `cfg_width` masks the word: 00 keeps bits 9:0, 01 keeps bits 11:0, 10 keeps bits 17:0, 11 keeps all 24 bits. Masked-off bits of `out_word` are 0.
- R2: Data bits at or above parameter `PIN_W` count as zero. With `PIN_W` = 12, bits 23:12 of `out_word` are always 0.
- R3: When `cfg_rise_edge` = 1, inputs are sampled on the rising edge of `px_clk`; when it is 0, on the falling edge. A sample shows at the outputs after the first rising edge that follows it.
- R4: After reset the outputs stay at zero, with `out_valid` low, for as long as `px_ctl[2]` (data enable) has not changed level between two captured samples.
- R5: The first captured sample whose data-enable level differs from the one before it is emitted. From then on every captured sample is emitted, so `out_valid` stays high until reset.
- R6: Control code 11 sends control bits with every emitted word. `out_ctl` copies `px_ctl` in the same bit order: bit 0 is line sync, bit 1 is frame sync, bit 2 is data enable.
- R7: Control code 10 sends control bits only on even words. A sample whose data enable is 1 while the previous captured sample had 0 is even. Otherwise each emitted word takes the opposite parity of the one before it, and the first word emitted after reset counts as even when it is not a data-enable rise.
- R8: Control codes 00 and 01 never send control bits: `out_ctl_present` stays 0.
- R9: An active-low asynchronous `rst_n` clears all outputs, the alignment state and the parity tracking.
- R10: Whenever `out_ctl_present` is 0, `out_ctl` is 0 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| px_clk | input | 1 | Pixel clock; all output registers use its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rise_edge | input | 1 | Sampling edge: 1 rising, 0 falling |
| cfg_width | input | 2 | Colour depth code (10/12/18/24 bits) |
| cfg_ctl_mode | input | 2 | Control insertion code: 00/01 none, 10 even words, 11 all words |
| px_data | input | 24 | Parallel pixel data |
| px_ctl | input | 3 | Bit 0 line sync, bit 1 frame sync, bit 2 data enable |
| out_valid | output | 1 | A formatted word is present this cycle |
| out_word | output | 24 | Masked pixel data, zero-extended |
| out_ctl | output | 3 | Control bits when present, otherwise 0 |
| out_ctl_present | output | 1 | Control bits travel with this word |

## Verification
A state machine stuck in the wrong state shows up at `out_valid` one rising edge after the sample it mishandles. If it leaves WAIT early, a word appears while data enable is still constant. If it misses the change, the stream never starts. If it drops out of RUN, `out_valid` falls in the middle of the stream. A wrong parity flag appears in control code 10, on the first word after a data-enable rise, as `out_ctl_present` on the wrong word of each pair. A capture register tied to the wrong edge gives word values that differ from those of the selected edge as soon as the data changes between the two edges.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    localparam int PIX_W  = 24;
    localparam int CTL_W  = 3;
    localparam int DE_BIT = 2;
    localparam int SMP_W  = PIX_W + CTL_W;

    typedef enum logic [1:0] {
        WD_10 = 2'b00,
        WD_12 = 2'b01,
        WD_18 = 2'b10,
        WD_24 = 2'b11
    } width_e;

    typedef enum logic [1:0] {
        CM_NONE = 2'b00,
        CM_RSVD = 2'b01,
        CM_EVEN = 2'b10,
        CM_ALL  = 2'b11
    } ctl_mode_e;

    typedef enum logic [1:0] {
        ST_ARM,
        ST_WAIT,
        ST_RUN
    } align_state_e;

    function automatic logic [PIX_W-1:0] width_mask(input width_e w);
        logic [PIX_W-1:0] m;
        unique case (w)
            WD_10:   m = PIX_W'((1 << 10) - 1);
            WD_12:   m = PIX_W'((1 << 12) - 1);
            WD_18:   m = PIX_W'((1 << 18) - 1);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pcf_edge_sampler.sv
module pcf_edge_sampler #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_rise,
    input  logic [W-1:0] din,
    output logic [W-1:0] smp,
    output logic         smp_vld
);

    logic [W-1:0] cap_r;
    logic [W-1:0] cap_f;
    logic         vld_r;
    logic         vld_f;

    // capture on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_r <= '0;
            vld_r <= 1'b0;
        end else begin
            cap_r <= din;
            vld_r <= 1'b1;
        end
    end

    // capture on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_f <= '0;
            vld_f <= 1'b0;
        end else begin
            cap_f <= din;
            vld_f <= 1'b1;
        end
    end

    assign smp     = sel_rise ? cap_r : cap_f;
    assign smp_vld = sel_rise ? vld_r : vld_f;

endmodule

// File: rtl/pcf_align_fsm.sv
module pcf_align_fsm
    import pcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic de,
    output logic emit,
    output logic de_rise
);

    align_state_e state_q;
    align_state_e state_d;
    logic         prev_de_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_ARM;
            prev_de_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (smp_vld) begin
                prev_de_q <= de;
            end
        end
    end

    // transitions: ARM->WAIT on first sample, WAIT->RUN on level change
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:  if (smp_vld) state_d = ST_WAIT;
            ST_WAIT: if (smp_vld && (de != prev_de_q)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_ARM;
        endcase
    end

    // outputs
    always_comb begin
        emit = 1'b0;
        unique case (state_q)
            ST_ARM:  emit = 1'b0;
            ST_WAIT: emit = smp_vld && (de != prev_de_q);
            ST_RUN:  emit = smp_vld;
            default: emit = 1'b0;
        endcase
        de_rise = de & ~prev_de_q;
    end

endmodule

// File: rtl/pcf_ctl_gate.sv
module pcf_ctl_gate
    import pcf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      emit,
    input  logic      de_rise,
    input  ctl_mode_e mode,
    output logic      present
);

    logic even_q;
    logic cur_even;

    assign cur_even = de_rise | even_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_q <= 1'b1;
        end else if (emit) begin
            even_q <= ~cur_even;
        end
    end

    always_comb begin
        present = 1'b0;
        unique case (mode)
            CM_ALL:  present = emit;
            CM_EVEN: present = emit & cur_even;
            CM_RSVD: present = 1'b0;
            default: present = 1'b0;
        endcase
    end

endmodule

// File: rtl/pix_capture_fmt.sv
module pix_capture_fmt
    import pcf_pkg::*;
#(
    parameter int PIN_W = 24
) (
    input  logic             px_clk,
    input  logic             rst_n,
    input  logic             cfg_rise_edge,
    input  logic [1:0]       cfg_width,
    input  logic [1:0]       cfg_ctl_mode,
    input  logic [PIX_W-1:0] px_data,
    input  logic [CTL_W-1:0] px_ctl,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_word,
    output logic [CTL_W-1:0] out_ctl,
    output logic             out_ctl_present
);

    logic [PIX_W-1:0] data_lim;
    logic [SMP_W-1:0] smp;
    logic             smp_vld;
    logic             emit;
    logic             de_rise;
    logic             present;
    logic [PIX_W-1:0] masked;

    // bits beyond the physical pins read as zero
    for (genvar i = 0; i < PIX_W; i++) begin : g_pin
        if (i < PIN_W) begin : g_keep
            assign data_lim[i] = px_data[i];
        end else begin : g_zero
            assign data_lim[i] = 1'b0;
        end
    end

    pcf_edge_sampler #(.W(SMP_W)) i_sampler (
        .clk     (px_clk),
        .rst_n   (rst_n),
        .sel_rise(cfg_rise_edge),
        .din     ({px_ctl, data_lim}),
        .smp     (smp),
        .smp_vld (smp_vld)
    );

    pcf_align_fsm i_align (
        .clk    (px_clk),
        .rst_n  (rst_n),
        .smp_vld(smp_vld),
        .de     (smp[PIX_W+DE_BIT]),
        .emit   (emit),
        .de_rise(de_rise)
    );

    pcf_ctl_gate i_gate (
        .clk    (px_clk),
        .rst_n  (rst_n),
        .emit   (emit),
        .de_rise(de_rise),
        .mode   (ctl_mode_e'(cfg_ctl_mode)),
        .present(present)
    );

    assign masked = smp[PIX_W-1:0] & width_mask(width_e'(cfg_width));

    always_ff @(posedge px_clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_word        <= '0;
            out_ctl         <= '0;
            out_ctl_present <= 1'b0;
        end else begin
            out_valid       <= emit;
            out_word        <= emit ? masked : '0;
            out_ctl         <= present ? smp[SMP_W-1:PIX_W] : '0;
            out_ctl_present <= present;
        end
    end

endmodule

// File: rtl/pix_capture_fmt_chk.sv
module pix_capture_fmt_chk
    import pcf_pkg::*;
#(
    parameter int PIN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_width,
    input logic [1:0]       cfg_ctl_mode,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_word,
    input logic [CTL_W-1:0] out_ctl,
    input logic             out_ctl_present
);

    logic [1:0] prev_w;
    logic [1:0] prev_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_w <= 2'b11;
            prev_m <= 2'b00;
        end else begin
            prev_w <= cfg_width;
            prev_m <= cfg_ctl_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!out_valid && out_word == '0 && out_ctl == '0 && !out_ctl_present); // R9
        end
    end

    AST_WIDTH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_word & ~width_mask(width_e'(prev_w))) == '0)); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_word == '0 && !out_ctl_present)); // R4

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid); // R5

    AST_ALL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && prev_m == 2'b11) |-> out_ctl_present); // R6

    AST_NONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_m == 2'b00 || prev_m == 2'b01) |-> !out_ctl_present); // R8

    AST_CTL_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ctl_present |-> (out_ctl == '0)); // R10

    if (PIN_W < PIX_W) begin : g_pin_chk
        AST_PIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            out_word[PIX_W-1:PIN_W] == '0); // R2
    end

endmodule

bind pix_capture_fmt pix_capture_fmt_chk #(.PIN_W(PIN_W)) i_chk (
    .clk            (px_clk),
    .rst_n          (rst_n),
    .cfg_width      (cfg_width),
    .cfg_ctl_mode   (cfg_ctl_mode),
    .out_valid      (out_valid),
    .out_word       (out_word),
    .out_ctl        (out_ctl),
    .out_ctl_present(out_ctl_present)
);

// File: tb/test_pix_capture_fmt.sv
module test_pix_capture_fmt;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rise = 1'b1;
    logic [1:0]  cfg_width = 2'b11;
    logic [1:0]  cfg_mode = 2'b11;
    logic [23:0] px_data = '0;
    logic [2:0]  px_ctl = 3'b100;

    logic        o_valid, n_valid;
    logic [23:0] o_word, n_word;
    logic [2:0]  o_ctl, n_ctl;
    logic        o_pres, n_pres;

    pix_capture_fmt i_pix_capture_fmt (
        .px_clk(clk), .rst_n(rst_n), .cfg_rise_edge(cfg_rise),
        .cfg_width(cfg_width), .cfg_ctl_mode(cfg_mode),
        .px_data(px_data), .px_ctl(px_ctl),
        .out_valid(o_valid), .out_word(o_word), .out_ctl(o_ctl),
        .out_ctl_present(o_pres)
    );

    pix_capture_fmt #(.PIN_W(12)) i_pix_capture_fmt_narrow (
        .px_clk(clk), .rst_n(rst_n), .cfg_rise_edge(cfg_rise),
        .cfg_width(cfg_width), .cfg_ctl_mode(cfg_mode),
        .px_data(px_data), .px_ctl(px_ctl),
        .out_valid(n_valid), .out_word(n_word), .out_ctl(n_ctl),
        .out_ctl_present(n_pres)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R9";
    bit    finished = 0;

    // reference model state
    bit          pos_seen, neg_seen;
    logic [26:0] pos_s, neg_s, smp;
    int          mst;
    bit          prev_de, nxt_even, have, emit, rise, even, de, pres;
    logic        exp_valid, exp_pres;
    logic [23:0] exp_word;
    logic [2:0]  exp_ctl;

    function automatic logic [23:0] depth_mask(input logic [1:0] w);
        case (w)
            2'b00:   return 24'h0003FF;
            2'b01:   return 24'h000FFF;
            2'b10:   return 24'h03FFFF;
            default: return 24'hFFFFFF;
        endcase
    endfunction

    function automatic logic [23:0] pat(input int i);
        logic [23:0] v;
        v = 24'(i * 32'h009E3779) ^ 24'h5A5A5A;
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            neg_seen = 0;
        end else begin
            neg_s    = {px_ctl, px_data};
            neg_seen = 1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            pos_seen = 0; mst = 0; prev_de = 0; nxt_even = 1;
            exp_valid = 0; exp_word = '0; exp_ctl = '0; exp_pres = 0;
        end else begin
            have = cfg_rise ? pos_seen : neg_seen;
            smp  = cfg_rise ? pos_s : neg_s;
            emit = 0;
            exp_valid = 0; exp_word = '0; exp_ctl = '0; exp_pres = 0;
            if (have) begin
                de = smp[26];
                if (mst == 0) mst = 1;
                else if (mst == 1 && de != prev_de) begin mst = 2; emit = 1; end
                else if (mst == 2) emit = 1;
                if (emit) begin
                    rise = de && !prev_de;
                    even = rise ? 1'b1 : nxt_even;
                    nxt_even = !even;
                    pres = (cfg_mode == 2'b11) || (cfg_mode == 2'b10 && even);
                    exp_valid = 1;
                    exp_word  = smp[23:0] & depth_mask(cfg_width);
                    exp_pres  = pres;
                    exp_ctl   = pres ? smp[26:24] : 3'b000;
                end
                prev_de = de;
            end
            pos_s    = {px_ctl, px_data};
            pos_seen = 1;
        end
        #1;
        if (!finished) begin
            chk(cur_req, "out_valid", 32'(o_valid), 32'(exp_valid));
            chk(cur_req, "out_word", 32'(o_word), 32'(exp_word));
            chk(cur_req, "out_ctl", 32'(o_ctl), 32'(exp_ctl));
            chk(cur_req, "out_ctl_present", 32'(o_pres), 32'(exp_pres));
            chk("R2", "narrow out_word", 32'(n_word), 32'(exp_word & 24'h000FFF));
            if (!o_pres) chk("R10", "out_ctl without flag", 32'(o_ctl), 32'd0);
        end
    end

    // value seen by the falling edge, then by the next rising edge
    task automatic drive(input logic [23:0] d1, input logic [2:0] c1,
                         input logic [23:0] d2, input logic [2:0] c2);
        @(posedge clk);
        #2; px_data = d1; px_ctl = c1;
        #5; px_data = d2; px_ctl = c2;
    endtask

    task automatic pix(input logic [23:0] d, input logic [2:0] c);
        drive(d, c, d, c);
    endtask

    task automatic line(input int n, input int seed);
        for (int k = 0; k < n; k++) pix(pat(seed + k), 3'b100);
    endtask

    task automatic blank(input int n, input int seed);
        for (int k = 0; k < n; k++) pix(pat(seed + k), (k == 0) ? 3'b001 : 3'b010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset out_valid", 32'(o_valid), 32'd0);
        chk("R9", "reset out_word", 32'(o_word), 32'd0);
        #1; rst_n = 1; cur_req = "R4";
        // data enable held high: nothing may leave
        for (int k = 0; k < 6; k++) pix(pat(k), 3'b100);
        cur_req = "R5";
        blank(3, 100);
        cur_req = "R6";
        line(5, 200); blank(2, 210); line(4, 220);
        cur_req = "R7";
        cfg_mode = 2'b10;
        blank(3, 300); line(5, 310); blank(3, 320); line(4, 330); blank(2, 340);
        cur_req = "R8";
        cfg_mode = 2'b00;
        line(3, 400); blank(2, 410);
        cfg_mode = 2'b01;
        line(3, 420); blank(2, 430);
        cur_req = "R1";
        cfg_mode = 2'b11;
        for (int w = 0; w < 3; w++) begin
            cfg_width = 2'(w);
            pix(24'hFFFFFF, 3'b100);
            line(3, 500 + 10 * w);
        end
        cfg_width = 2'b11;
        cur_req = "R3";
        cfg_rise = 1'b0;
        for (int k = 0; k < 5; k++) drive(pat(600 + k), 3'b100, pat(650 + k), 3'b001);
        cfg_rise = 1'b1;
        for (int k = 0; k < 5; k++) drive(pat(700 + k), 3'b010, pat(750 + k), 3'b100);
        // reset in the middle of the stream
        cur_req = "R9";
        @(posedge clk); #2; rst_n = 0;
        repeat (2) @(posedge clk);
        #2; cfg_rise = 1'b0; cfg_mode = 2'b10; rst_n = 1;
        cur_req = "R4";
        for (int k = 0; k < 4; k++) pix(pat(800 + k), 3'b001);
        cur_req = "R7";
        line(5, 850); blank(3, 860); line(3, 870);
        pix(24'h0, 3'b000);
        @(posedge clk); #3;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R5 watchdog expired actual=running expected=done");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule